// File: doc/BRIEF.md
# DDR Read Burst Output Scheduler

This block is the read data path on the device side of a double-data-rate SDRAM. Each clock it takes one decoded command: a no-op, a READ with bank and column, a WRITE, or a BURST STOP. Each READ becomes a burst of BL beats. The beats leave in pairs, one pair per clock, on a double-width data word. The first pair appears CL clocks after the READ. An output-enable for the data drivers and a strobe-valid flag go with the data. The array contents come from a fixed arithmetic lookup, so the data path can be checked without a real memory.

A later READ may cut a burst short. It needs to be only one clock after the earlier READ, and it may target any bank. Both bursts are in flight together for a while: the older burst keeps the bus until the newer READ's latency runs out. From that clock the newer burst delivers all of its beats, starting at its own column. To hand the bus to a write, the controller must first issue BURST STOP. BURST STOP ends the burst on the bus CL clocks later. The WRITE must then follow at least CL clocks after the BURST STOP. The block raises a one-clock protocol-error pulse when a WRITE breaks either spacing rule.

Top module: `ddr_rd_sched`

## Requirements
- R1: cmd_i encodes 0 as NOP, 1 as READ, 2 as WRITE and 3 as BURST STOP. Take a READ sampled at edge k that nothing cuts short. It yields BL/2 beat pairs on dq_o, one after each edge from k+CL to k+CL+BL/2-1, and dq_oe_o is high for exactly those cycles.
- R2: Let a burst start at column c. Beat i of that burst reads column c with its low log2(BL) bits replaced by ((c mod BL)+i) mod BL, so the burst wraps inside its BL-aligned block. The even beat of each pair sits in the low DW bits of dq_o and the odd beat in the high DW bits.
- R3: The word stored at bank b, column c is (977*b + 3*c + 0x1234) mod 2^DW.
- R4: Suppose a READ at edge k+d (d >= 1) follows a READ at edge k with no BURST STOP between them. The older burst shows only its pairs due after edges k+CL to k+CL+d-1. The newer burst then shows all BL/2 of its pairs from edge k+d+CL, with no idle cycle in between.
- R5: After a BURST STOP at edge s, no pair of the stopped burst appears after edge s+CL-1. dq_oe_o stays low from edge s+CL until data from a later READ arrives.
- R6: Both bits of beat_vld_o equal dq_oe_o, and dq_o is zero whenever dq_oe_o is low.
- R7: dqs_vld_o is high whenever dq_oe_o is high. It is also high in the cycle just before a pair appears after an idle cycle, as a preamble. It is low at all other times.
- R8: Take a WRITE at edge t whose most recent READ was at edge k, with no BURST STOP after that READ. If t-k <= CL+BL/2, proto_err_o is high for the one cycle after edge t.
- R9: Take a WRITE at edge t whose most recent READ-or-BURST-STOP is a BURST STOP at edge s. proto_err_o is high after edge t if and only if t-s < CL.
- R10: A WRITE never changes dq_o, dq_oe_o or dqs_vld_o. A WRITE with no READ in the previous CL+BL/2 clocks and no BURST STOP in the previous CL-1 clocks leaves proto_err_o low.
- R11: While rst_n is low, and in the first cycle after it rises, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 2 | Decoded command (0 NOP, 1 READ, 2 WRITE, 3 BURST STOP) |
| bank_i | input | BKW | Bank of a READ |
| col_i | input | CW | Start column of a READ |
| dq_o | output | 2*DW | Beat pair: even beat low, odd beat high |
| beat_vld_o | output | 2 | Per-half valid bits of dq_o |
| dq_oe_o | output | 1 | Output-driver enable for the data bus |
| dqs_vld_o | output | 1 | Strobe valid, including the one-cycle preamble |
| proto_err_o | output | 1 | One-cycle pulse for a misplaced WRITE |

## Verification
Reads that run to completion are tried across every bank and across start columns that are aligned, unaligned and at the top of the column range. This separates the wrap-order logic from the data lookup. Interrupting reads are swept over spacings from one clock up to one clock beyond a whole burst. This shows that the hand-over edge follows the newer command's latency and not the older burst's end. Back-to-back reads every clock test repeated truncation. BURST STOP is swept over its offset into the burst and over every gap to the following WRITE, on both sides of the latency bound. Writes with no stop, and writes after a stop followed by a fresh READ, separate the two error causes from each other and from legal idle writes.

// File: rtl/rb_sched_pkg.sv
// rb_sched_pkg
// Shared command encoding and the array lookup used by the read scheduler.
// Assumes the data width of the caller is at most 32 bits.
package rb_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_BSTOP = 2'd3
    } rb_cmd_e;

    // Contents of one array cell; a fixed mix of bank and column.
    function automatic logic [31:0] rb_cell_word(input logic [31:0] bank,
                                                 input logic [31:0] col);
        return bank * 32'd977 + col * 32'd3 + 32'h0000_1234;
    endfunction

endpackage

// File: rtl/rb_burst_gen.sv
// rb_burst_gen
// Issues the column pairs of the current burst at the rate of one pair
// per clock, starting in the edge that accepts the READ. A new READ
// restarts it from its own column, discarding what was left of the old
// burst. A stop ends it at once. Columns wrap inside the BL-aligned block.
// Assumes BL is 2, 4 or 8.
module rb_burst_gen #(
    parameter int BL  = 4,
    parameter int CW  = 10,
    parameter int BKW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_go,
    input  logic           stop,
    input  logic [BKW-1:0] bank_i,
    input  logic [CW-1:0]  col_i,
    output logic           pv_o,
    output logic [BKW-1:0] pbank_o,
    output logic [CW-1:0]  pcol0_o,
    output logic [CW-1:0]  pcol1_o
);
    localparam int NP = BL / 2;
    localparam int LB = $clog2(BL);
    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    logic           act_q;
    logic [BKW-1:0] bank_q;
    logic [CW-1:0]  start_q;
    logic [IW-1:0]  idx_q;
    logic [LB-1:0]  off0;
    logic [LB-1:0]  off1;

    // Burst state: load on READ, clear on stop, step through the pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            bank_q  <= '0;
            start_q <= '0;
            idx_q   <= '0;
        end else if (rd_go) begin
            act_q   <= 1'b1;
            bank_q  <= bank_i;
            start_q <= col_i;
            idx_q   <= '0;
        end else if (stop) begin
            act_q   <= 1'b0;
        end else if (act_q) begin
            if (idx_q == IW'(NP - 1)) begin
                act_q <= 1'b0;
            end else begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    // Wrapped offsets of the two beats in the current pair.
    always_comb begin
        off0 = start_q[LB-1:0] + LB'({idx_q, 1'b0});
        off1 = off0 + LB'(1);
    end

    assign pv_o    = act_q;
    assign pbank_o = bank_q;
    assign pcol0_o = {start_q[CW-1:LB], off0};
    assign pcol1_o = {start_q[CW-1:LB], off1};

endmodule

// File: rtl/rb_out_pipe.sv
// rb_out_pipe
// Delays each issued pair by CL clocks in total. CL-1 stages carry the
// address. The last register reads the array and drives the bus, so the
// lookup acts as a synchronous read. Also gives the strobe-valid flag,
// which includes a one-cycle preamble, and a busy flag for the guard.
// Assumes CL >= 2 and DW <= 32.
module rb_out_pipe #(
    parameter int CL  = 3,
    parameter int CW  = 10,
    parameter int BKW = 2,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pv_i,
    input  logic [BKW-1:0] pbank_i,
    input  logic [CW-1:0]  pcol0_i,
    input  logic [CW-1:0]  pcol1_i,
    output logic [2*DW-1:0] dq_o,
    output logic [1:0]     beat_vld_o,
    output logic           oe_o,
    output logic           dqs_o,
    output logic           busy_o
);
    import rb_sched_pkg::*;

    localparam int NS = CL - 1;

    logic           sv [NS];
    logic [BKW-1:0] sb [NS];
    logic [CW-1:0]  sc0 [NS];
    logic [CW-1:0]  sc1 [NS];
    logic [DW-1:0]  lane_w [2];
    logic           oe_q;
    logic [2*DW-1:0] dq_q;
    logic           any_stage;

    // Address delay line: shift every stage by one each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                sv[i]  <= 1'b0;
                sb[i]  <= '0;
                sc0[i] <= '0;
                sc1[i] <= '0;
            end
        end else begin
            sv[0]  <= pv_i;
            sb[0]  <= pbank_i;
            sc0[0] <= pcol0_i;
            sc1[0] <= pcol1_i;
            for (int i = 1; i < NS; i++) begin
                sv[i]  <= sv[i-1];
                sb[i]  <= sb[i-1];
                sc0[i] <= sc0[i-1];
                sc1[i] <= sc1[i-1];
            end
        end
    end

    // One array lookup per beat lane, from the last address stage.
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [CW-1:0] lane_col;
        assign lane_col   = (ln == 0) ? sc0[NS-1] : sc1[NS-1];
        assign lane_w[ln] = DW'(rb_cell_word(32'(sb[NS-1]), 32'(lane_col)));
    end

    // Bus register: data and enable, with data forced to zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
            dq_q <= '0;
        end else begin
            oe_q <= sv[NS-1];
            dq_q <= sv[NS-1] ? {lane_w[1], lane_w[0]} : '0;
        end
    end

    // Any pair still travelling through the address stages.
    always_comb begin
        any_stage = 1'b0;
        for (int i = 0; i < NS; i++) begin
            any_stage = any_stage | sv[i];
        end
    end

    assign dq_o       = dq_q;
    assign beat_vld_o = {oe_q, oe_q};
    assign oe_o       = oe_q;
    assign dqs_o      = oe_q | sv[NS-1];
    assign busy_o     = pv_i | any_stage | oe_q;

endmodule

// File: rtl/rb_bus_guard.sv
// rb_bus_guard
// Enforces the spacing rules for a WRITE. It remembers whether the last
// READ-or-stop event was a stop, and counts the clocks since that stop,
// saturating at CL. A WRITE raises the error pulse in either case:
// - the read data is still pending and no stop came after the last READ;
// - the stop came fewer than CL clocks before the WRITE.
// Assumes CL >= 2.
module rb_bus_guard #(
    parameter int CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_read,
    input  logic is_write,
    input  logic is_stop,
    input  logic busy_i,
    output logic err_o
);
    localparam int GW = $clog2(CL + 1);

    logic          stopped_q;
    logic [GW-1:0] gap_q;
    logic          err_q;

    // Stop tracking: arm on stop, disarm on READ, count clocks since stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped_q <= 1'b0;
            gap_q     <= GW'(CL);
        end else if (is_stop) begin
            stopped_q <= 1'b1;
            gap_q     <= GW'(1);
        end else begin
            if (is_read) begin
                stopped_q <= 1'b0;
            end
            if (gap_q < GW'(CL)) begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    // Error pulse: one cycle after a WRITE that breaks a spacing rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= is_write &&
                     ((busy_i && !stopped_q) || (stopped_q && (gap_q < GW'(CL))));
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/ddr_rd_sched.sv
// ddr_rd_sched
// Read data scheduler of a DDR device. It decodes the command and issues
// burst pairs. It delays them by the CAS latency onto a double-width bus
// and guards the stop-before-write spacing.
// Assumes BL in {2,4,8}, CL in {2,3}, DW <= 32. One command per clock.
module ddr_rd_sched #(
    parameter int BL  = 4,
    parameter int CL  = 3,
    parameter int CW  = 10,
    parameter int BKW = 2,
    parameter int DW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cmd_i,
    input  logic [BKW-1:0]  bank_i,
    input  logic [CW-1:0]   col_i,
    output logic [2*DW-1:0] dq_o,
    output logic [1:0]      beat_vld_o,
    output logic            dq_oe_o,
    output logic            dqs_vld_o,
    output logic            proto_err_o
);
    import rb_sched_pkg::*;

    rb_cmd_e        cmd;
    logic           is_read;
    logic           is_write;
    logic           is_stop;
    logic           pv;
    logic [BKW-1:0] pbank;
    logic [CW-1:0]  pcol0;
    logic [CW-1:0]  pcol1;
    logic           busy;

    // Command decode.
    always_comb begin
        cmd      = rb_cmd_e'(cmd_i);
        is_read  = (cmd == CMD_READ);
        is_write = (cmd == CMD_WRITE);
        is_stop  = (cmd == CMD_BSTOP);
    end

    rb_burst_gen #(.BL(BL), .CW(CW), .BKW(BKW)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (is_read),
        .stop    (is_stop),
        .bank_i  (bank_i),
        .col_i   (col_i),
        .pv_o    (pv),
        .pbank_o (pbank),
        .pcol0_o (pcol0),
        .pcol1_o (pcol1)
    );

    rb_out_pipe #(.CL(CL), .CW(CW), .BKW(BKW), .DW(DW)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .pv_i       (pv),
        .pbank_i    (pbank),
        .pcol0_i    (pcol0),
        .pcol1_i    (pcol1),
        .dq_o       (dq_o),
        .beat_vld_o (beat_vld_o),
        .oe_o       (dq_oe_o),
        .dqs_o      (dqs_vld_o),
        .busy_o     (busy)
    );

    rb_bus_guard #(.CL(CL)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_read  (is_read),
        .is_write (is_write),
        .is_stop  (is_stop),
        .busy_i   (busy),
        .err_o    (proto_err_o)
    );

endmodule

// File: rtl/rb_sched_chk.sv
// rb_sched_chk
// Temporal checks on the scheduler ports, bound into ddr_rd_sched.
// Small counters measure the age of the last READ and of the last stop,
// so that no property looks back a parameter-sized number of cycles.
module rb_sched_chk #(
    parameter int CL = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_i,
    input logic       dq_oe_o,
    input logic       dqs_vld_o,
    input logic       proto_err_o
);
    localparam int AW = $clog2(CL + 2);

    logic [AW-1:0] stop_age;
    logic [AW-1:0] rd_age;

    // Clocks since the last stop, cleared by a READ, saturating at CL+1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_age <= '0;
        end else if (cmd_i == 2'd3) begin
            stop_age <= AW'(1);
        end else if (cmd_i == 2'd1) begin
            stop_age <= '0;
        end else if (stop_age != '0 && stop_age < AW'(CL + 1)) begin
            stop_age <= stop_age + AW'(1);
        end
    end

    // Clocks since the last READ, cleared by a stop, saturating at CL+1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_age <= '0;
        end else if (cmd_i == 2'd1) begin
            rd_age <= AW'(1);
        end else if (cmd_i == 2'd3) begin
            rd_age <= '0;
        end else if (rd_age != '0 && rd_age < AW'(CL + 1)) begin
            rd_age <= rd_age + AW'(1);
        end
    end

    // R1
    read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_age == AW'(CL)) |=> dq_oe_o);

    // R5
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_age > AW'(CL)) |-> !dq_oe_o);

    // R7
    strobe_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> dqs_vld_o);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(cmd_i == 2'd2));

    // R9
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd2 && stop_age != '0 && stop_age < AW'(CL)) |=> proto_err_o);

endmodule

bind ddr_rd_sched rb_sched_chk #(.CL(CL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .dq_oe_o     (dq_oe_o),
    .dqs_vld_o   (dqs_vld_o),
    .proto_err_o (proto_err_o)
);

// File: tb/sim_ddr_rd_sched.sv
`timescale 1ns/1ps
module sim_ddr_rd_sched;
    localparam int BL  = 4;
    localparam int CL  = 3;
    localparam int CW  = 10;
    localparam int BKW = 2;
    localparam int DW  = 16;
    localparam int NP  = BL / 2;

    logic            clk;
    logic            rst_n;
    logic [1:0]      cmd_i;
    logic [BKW-1:0]  bank_i;
    logic [CW-1:0]   col_i;
    logic [2*DW-1:0] dq_o;
    logic [1:0]      beat_vld_o;
    logic            dq_oe_o;
    logic            dqs_vld_o;
    logic            proto_err_o;

    int nchk = 0;
    int nerr = 0;
    int n    = 0;
    bit done = 0;
    int h_cmd [64];
    int h_bank [64];
    int h_col [64];

    ddr_rd_sched #(.BL(BL), .CL(CL), .CW(CW), .BKW(BKW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
        .dq_o(dq_o), .beat_vld_o(beat_vld_o), .dq_oe_o(dq_oe_o),
        .dqs_vld_o(dqs_vld_o), .proto_err_o(proto_err_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s edge %0d actual %0h expected %0h", tag, n, act, exp);
        end
    endtask

    // R3 word formula
    function automatic logic [DW-1:0] bword(input int b, input int c);
        logic [31:0] w;
        w = 977 * b + 3 * c + 32'h1234;
        return w[DW-1:0];
    endfunction

    // R2 wrap order
    function automatic int colof(input int c, input int i);
        return (c - (c % BL)) + (((c % BL) + i) % BL);
    endfunction

    // Latest READ (1) or stop (3) at an edge <= e, looking back lim edges.
    function automatic int find_last(input int e, input int lim);
        for (int i = 0; i < lim; i++) begin
            if (e - i < 0) return -1;
            if (h_cmd[(e - i) % 64] == 1 || h_cmd[(e - i) % 64] == 3) return e - i;
        end
        return -1;
    endfunction

    // Expected bus contents after edge t (R1 R4 R5).
    task automatic exp_out(input int t, output bit v, output logic [63:0] d);
        int e;
        int k;
        int j;
        int b;
        int c;
        v = 0;
        d = '0;
        e = t - CL;
        if (e < 0) return;
        k = find_last(e, NP);
        if (k >= 0 && h_cmd[k % 64] == 1) begin
            j = e - k;
            b = h_bank[k % 64];
            c = h_col[k % 64];
            v = 1;
            d = 64'({bword(b, colof(c, 2 * j + 1)), bword(b, colof(c, 2 * j))});
        end
    endtask

    // Expected error pulse after edge t (R8 R9 R10).
    function automatic bit exp_err(input int t);
        int k;
        if (h_cmd[t % 64] != 2) return 0;
        k = find_last(t - 1, 20);
        if (k < 0) return 0;
        if (h_cmd[k % 64] == 3) return (t - k) < CL;
        return (t - k) <= CL + NP;
    endfunction

    // Drive one command for the next edge, then check every output after it.
    task automatic tick(input int c, input int b, input int col, input string scen);
        bit v0;
        bit v1;
        logic [63:0] d0;
        logic [63:0] d1;
        h_cmd[n % 64]  = rst_n ? c : 0;
        h_bank[n % 64] = b;
        h_col[n % 64]  = col;
        cmd_i  = 2'(c);
        bank_i = BKW'(b);
        col_i  = CW'(col);
        @(posedge clk);
        #1;
        exp_out(n, v0, d0);
        exp_out(n + 1, v1, d1);
        chk({"R1 oe ", scen}, 64'(dq_oe_o), 64'(v0));
        chk({"R6 beat_vld ", scen}, 64'(beat_vld_o), 64'({v0, v0}));
        chk({"R3 dq ", scen}, 64'(dq_o), d0);
        chk({"R7 dqs ", scen}, 64'(dqs_vld_o), 64'(v0 | v1));
        chk({"R8 err ", scen}, 64'(proto_err_o), 64'(exp_err(n)));
        n++;
    endtask

    task automatic idle(input int cnt, input string scen);
        for (int i = 0; i < cnt; i++) tick(0, 0, 0, scen);
    endtask

    initial begin
        int cols [7];
        cols = '{0, 1, 2, 3, 6, 1021, 1023};
        rst_n  = 1'b0;
        cmd_i  = '0;
        bank_i = '0;
        col_i  = '0;
        // R11 reset state, including a READ presented during reset
        tick(0, 0, 0, "R11 reset");
        tick(1, 1, 5, "R11 reset");
        idle(3, "R11 reset");
        chk("R11 reset outputs", 64'({dq_o, beat_vld_o, dq_oe_o, dqs_vld_o, proto_err_o}), 64'd0);
        rst_n = 1'b1;
        idle(CL + 2, "R11 after reset");

        // R2 single reads over banks and columns
        for (int b = 0; b < 4; b++)
            for (int ci = 0; ci < 7; ci++) begin
                tick(1, b, cols[ci], "R2 single");
                idle(CL + NP + 1, "R2 single");
            end

        // R4 interrupting reads at spacings 1 .. NP+1
        for (int d = 1; d <= NP + 1; d++)
            for (int p = 0; p < 2; p++) begin
                tick(1, 1, p ? 3 : 0, "R4 interrupt");
                idle(d - 1, "R4 interrupt");
                tick(1, 2, p ? 2 : 5, "R4 interrupt");
                idle(CL + NP + 1, "R4 interrupt");
            end

        // R4 a READ on every clock
        for (int i = 0; i < 6; i++) tick(1, i % 4, 7 * i + 1, "R4 chain");
        idle(CL + NP + 1, "R4 chain");

        // R5 R9 stop at each offset, then WRITE at each gap
        for (int off = 1; off <= NP + 1; off++)
            for (int g = 1; g <= CL + 1; g++) begin
                tick(1, 3, 9, "R5 R9 stop");
                idle(off - 1, "R5 R9 stop");
                tick(3, 0, 0, "R5 R9 stop");
                idle(g - 1, "R5 R9 stop");
                tick(2, 0, 0, "R5 R9 write");
                idle(CL + NP + 1, "R5 R9 stop");
            end

        // R8 R10 WRITE without a stop at each distance after a READ
        for (int j = 0; j <= CL + NP + 1; j++) begin
            tick(1, 2, 12, "R8 R10 nostop");
            idle(j, "R8 R10 nostop");
            tick(2, 0, 0, "R8 R10 nostop");
            idle(CL + NP + 1, "R8 R10 nostop");
        end

        // R10 WRITE on an idle bus
        tick(2, 0, 0, "R10 idle write");
        idle(2, "R10 idle write");

        // R8 stop, then a fresh READ clears the stop, then WRITE
        tick(3, 0, 0, "R8 restart");
        idle(CL, "R8 restart");
        tick(1, 1, 4, "R8 restart");
        tick(2, 0, 0, "R8 restart");
        idle(CL + NP + 1, "R8 restart");

        // R9 stop on an idle bus, then an early WRITE
        tick(3, 0, 0, "R9 idle stop");
        tick(2, 0, 0, "R9 idle stop");
        idle(2, "R9 idle stop");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL R1 watchdog expired at edge %0d actual running expected finished", n);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule